// File: doc/BRIEF.md
# Parity-Protected Conversion Result Memory

This block holds conversion results in a small word memory and keeps one odd-parity bit beside every 16-bit word. Results arrive on a converter-side write port. A CPU bus port reads the words back. The CPU can also overwrite them, but only while a direct-write enable is set. Every stored word gets fresh parity at the moment it is written, whichever path wrote it. An auto-initialization sequence clears the whole memory to zero and stores valid parity for each word.

A parity control register arms the check and holds a test bit. While the test bit is set, the parity bits appear in a second bus window, one per 32-bit location, so software can corrupt them on purpose. Once the test bit is cleared, reading the affected word raises a sticky error flag. The block also records the word address of the first failing read until software clears the flag.

The CPU address is a 14-bit byte offset. Bits [13:12] select the region: 0 is the data window, 1 is the parity window at offset 0x1000, and 2 is the register block at 0x2000. Region 3 reads as zero and ignores writes. Bits [AW+1:2] select the word, and bits [3:2] select the register.

Top module: `par_result_ram`

## Requirements
- R1: Parity is odd. The stored bit is the inverse of the XOR of the 16 data bits, so an all-zero word stores parity 1.
- R2: A pulse on init_start_i while idle holds init_busy_o high for exactly DEPTH cycles. During that time every word is written to zero with parity 1. A start pulse during the sequence is ignored. Converter writes and CPU memory writes made during the sequence are dropped.
- R3: A converter write (conv_we_i) stores conv_data_i at conv_addr_i and regenerates that word's parity. This overwrites any parity bit that was corrupted earlier.
- R4: A CPU write to the data window stores wdata[15:0] only while bit 0 of the operating-mode register (offset 0x2004) is 1. Otherwise the write leaves the word unchanged.
- R5: A CPU data write that is accepted regenerates the parity of the written word.
- R6: The parity control register is at offset 0x2000. Checking is armed only when bits [3:0] hold 0xA. With any other value, reads never raise an error.
- R7: Bit 8 of the parity control register is the test bit. While it is 1, the parity window reads and writes each word's parity bit at bit 0, with bits [31:1] reading as 0. While it is 0, parity-window reads return 0 and parity-window writes are ignored.
- R8: A CPU read of the data window sets the error flag when all three hold: checking is armed, the test bit is 0, and the word's data and parity have even combined parity.
- R9: The error flag is bit 0 at offset 0x2008 and drives par_err_o. It stays set until the CPU writes 1 to that bit. Writing 0 has no effect.
- R10: The error address register (offset 0x200C, read-only) captures the word index of the read that set the flag. It keeps that value while the flag stays set, even if later reads also fail.
- R11: Reads of the parity window never raise the error flag.
- R12: When conv_we_i and a CPU write to the data or parity window fall in the same cycle, the converter write is performed and the CPU write is dropped.
- R13: cpu_rdata_o holds the read result from the cycle after the request. Data-window reads are zero-extended to 32 bits, region 3 reads 0, and all outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_start_i | input | 1 | Start pulse for the clearing sequence |
| init_busy_o | output | 1 | Clearing sequence in progress |
| conv_we_i | input | 1 | Converter result write strobe |
| conv_addr_i | input | AW | Converter result word index |
| conv_data_i | input | 16 | Converter result data |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | 14 | CPU byte offset |
| cpu_wdata_i | input | 32 | CPU write data |
| cpu_rdata_o | output | 32 | CPU read data, registered |
| par_err_o | output | 1 | Sticky parity error flag |

## Verification
The hardest state to reach is a word whose stored parity disagrees with its data. The data paths always write consistent parity, so a bad bit can only come from a test-mode write to the parity window. Any converter or CPU data write to that word in between repairs the damage. The stimulus arms the check and sets the test bit, then inverts a parity bit and clears the test bit. It reads the word before anything else writes it. Random traffic then mixes converter writes, data writes, parity-window writes and register changes, so corruptions sometimes survive until a read and are sometimes repaired first.

// File: rtl/par_ram_pkg.sv
package par_ram_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned BADDR_W  = 14;
  localparam logic [3:0]  CHK_KEY  = 4'hA;
  localparam int unsigned TEST_BIT = 8;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_PAR  = 2'd1,
    RG_CSR  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CSR_PCTL = 2'd0,
    CSR_MODE = 2'd1,
    CSR_STAT = 2'd2,
    CSR_EADR = 2'd3
  } csr_e;
endpackage

// File: rtl/par_init_seq.sv
module par_init_seq #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [AW-1:0] idx_o
);
  logic          busy_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      if (cnt_q == AW'(DEPTH - 1)) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = cnt_q;
endmodule

// File: rtl/par_mem.sv
module par_mem #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned DW = par_ram_pkg::WORD_W
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pwe_i,
  input  logic [AW-1:0] pidx_i,
  input  logic          pbit_i,
  input  logic [AW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o,
  output logic          rpar_o,
  output logic [DW-1:0] data_o [DEPTH],
  output logic          par_o  [DEPTH]
);
  logic [DW-1:0] data_q [DEPTH];
  logic          par_q  [DEPTH];

  // full write port always stores fresh odd parity; pwe is the test-window path
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      data_q[widx_i] <= wdata_i;
      par_q[widx_i]  <= ~^wdata_i;
    end
    if (pwe_i) par_q[pidx_i] <= pbit_i;
  end

  assign rdata_o = data_q[ridx_i];
  assign rpar_o  = par_q[ridx_i];
  assign data_o  = data_q;
  assign par_o   = par_q;
endmodule

// File: rtl/par_ctrl_regs.sv
module par_ctrl_regs
  import par_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [1:0]       csr_sel_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             fail_i,
  input  logic [AW-1:0]    fail_idx_i,
  output logic             chk_en_o,
  output logic             test_o,
  output logic             dw_en_o,
  output logic             err_o,
  output logic [AW-1:0]    err_idx_o,
  output logic [BUS_W-1:0] csr_rdata_o
);
  logic [3:0]    key_q;
  logic          test_q, dw_q, err_q;
  logic [AW-1:0] eidx_q;
  logic          clr;
  logic          unused_wdata;

  assign unused_wdata = ^{wdata_i[BUS_W-1:TEST_BIT+1], wdata_i[TEST_BIT-1:4]};
  assign clr = csr_we_i && (csr_e'(csr_sel_i) == CSR_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      test_q <= 1'b0;
      dw_q   <= 1'b0;
      err_q  <= 1'b0;
      eidx_q <= '0;
    end else begin
      if (csr_we_i && csr_e'(csr_sel_i) == CSR_PCTL) begin
        key_q  <= wdata_i[3:0];
        test_q <= wdata_i[TEST_BIT];
      end
      if (csr_we_i && csr_e'(csr_sel_i) == CSR_MODE) dw_q <= wdata_i[0];
      if (clr) begin
        err_q <= 1'b0;
      end else if (fail_i && !err_q) begin
        err_q  <= 1'b1;
        eidx_q <= fail_idx_i;
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    unique case (csr_e'(csr_sel_i))
      CSR_PCTL: begin
        csr_rdata_o[3:0]      = key_q;
        csr_rdata_o[TEST_BIT] = test_q;
      end
      CSR_MODE: csr_rdata_o[0]    = dw_q;
      CSR_STAT: csr_rdata_o[0]    = err_q;
      CSR_EADR: csr_rdata_o[AW-1:0] = eidx_q;
    endcase
  end

  assign chk_en_o  = (key_q == CHK_KEY);
  assign test_o    = test_q;
  assign dw_en_o   = dw_q;
  assign err_o     = err_q;
  assign err_idx_o = eidx_q;
endmodule

// File: rtl/par_result_ram.sv
module par_result_ram
  import par_ram_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_start_i,
  output logic               init_busy_o,
  input  logic               conv_we_i,
  input  logic [AW-1:0]      conv_addr_i,
  input  logic [WORD_W-1:0]  conv_data_i,
  input  logic               cpu_req_i,
  input  logic               cpu_we_i,
  input  logic [BADDR_W-1:0] cpu_addr_i,
  input  logic [BUS_W-1:0]   cpu_wdata_i,
  output logic [BUS_W-1:0]   cpu_rdata_o,
  output logic               par_err_o
);
  region_e           region;
  logic [AW-1:0]     cpu_idx;
  logic              cpu_wr, cpu_rd;
  logic              init_busy, init_we;
  logic [AW-1:0]     init_idx;
  logic              chk_en, test_mode, dw_en, err_flag;
  logic [AW-1:0]     err_idx;
  logic [BUS_W-1:0]  csr_rdata;
  logic              conv_ok, cpu_dwr, cpu_pwr, mem_we, chk_fail;
  logic [AW-1:0]     mem_widx;
  logic [WORD_W-1:0] mem_wdata, rd_data;
  logic              rd_par;
  logic [WORD_W-1:0] mem_data [DEPTH];
  logic              mem_par  [DEPTH];
  logic [BUS_W-1:0]  rdata_d, rdata_q;
  logic              unused_addr;

  assign region      = region_e'(cpu_addr_i[13:12]);
  assign cpu_idx     = cpu_addr_i[AW+1:2];
  assign unused_addr = ^{cpu_addr_i[11:AW+2], cpu_addr_i[1:0]};
  assign cpu_wr      = cpu_req_i && cpu_we_i;
  assign cpu_rd      = cpu_req_i && !cpu_we_i;

  par_init_seq #(.DEPTH(DEPTH)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(init_start_i),
    .busy_o (init_busy),
    .idx_o  (init_idx)
  );
  assign init_we = init_busy;

  // priority: init sequence, then converter, then CPU
  assign conv_ok = conv_we_i && !init_busy;
  assign cpu_dwr = cpu_wr && region == RG_DATA && dw_en && !init_busy && !conv_we_i;
  assign cpu_pwr = cpu_wr && region == RG_PAR && test_mode && !init_busy && !conv_we_i;
  assign mem_we  = init_we || conv_ok || cpu_dwr;

  always_comb begin
    if (init_we) begin
      mem_widx  = init_idx;
      mem_wdata = '0;
    end else if (conv_ok) begin
      mem_widx  = conv_addr_i;
      mem_wdata = conv_data_i;
    end else begin
      mem_widx  = cpu_idx;
      mem_wdata = cpu_wdata_i[WORD_W-1:0];
    end
  end

  par_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .widx_i (mem_widx),
    .wdata_i(mem_wdata),
    .pwe_i  (cpu_pwr),
    .pidx_i (cpu_idx),
    .pbit_i (cpu_wdata_i[0]),
    .ridx_i (cpu_idx),
    .rdata_o(rd_data),
    .rpar_o (rd_par),
    .data_o (mem_data),
    .par_o  (mem_par)
  );

  assign chk_fail = cpu_rd && region == RG_DATA && chk_en && !test_mode
                    && !(^{rd_data, rd_par});

  par_ctrl_regs #(.DEPTH(DEPTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csr_we_i   (cpu_wr && region == RG_CSR),
    .csr_sel_i  (cpu_addr_i[3:2]),
    .wdata_i    (cpu_wdata_i),
    .fail_i     (chk_fail),
    .fail_idx_i (cpu_idx),
    .chk_en_o   (chk_en),
    .test_o     (test_mode),
    .dw_en_o    (dw_en),
    .err_o      (err_flag),
    .err_idx_o  (err_idx),
    .csr_rdata_o(csr_rdata)
  );

  always_comb begin
    rdata_d = '0;
    unique case (region)
      RG_DATA: rdata_d = BUS_W'(rd_data);
      RG_PAR:  rdata_d = test_mode ? BUS_W'(rd_par) : '0;
      RG_CSR:  rdata_d = csr_rdata;
      RG_NONE: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (cpu_rd) rdata_q <= rdata_d;
  end

  assign cpu_rdata_o = rdata_q;
  assign init_busy_o = init_busy;
  assign par_err_o   = err_flag;
endmodule

// File: rtl/par_result_ram_chk.sv
module par_result_ram_chk #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          init_start_i,
  input logic          init_busy_o,
  input logic          conv_we_i,
  input logic [AW-1:0] conv_addr_i,
  input logic [15:0]   conv_data_i,
  input logic          cpu_req_i,
  input logic          cpu_we_i,
  input logic [1:0]    addr_region,
  input logic [1:0]    addr_sel,
  input logic [AW-1:0] addr_idx,
  input logic          wdata_b0,
  input logic          par_err_o,
  input logic [15:0]   mem_data [DEPTH],
  input logic          mem_par  [DEPTH],
  input logic [AW-1:0] err_idx
);
  logic          clr;
  logic          cv_q, pr_q;
  logic [AW-1:0] ca_q, pidx_q;
  logic [15:0]   cd_q, pold_q;

  assign clr = cpu_req_i && cpu_we_i && addr_region == 2'd2 && addr_sel == 2'd2 && wdata_b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_q <= 1'b0; pr_q <= 1'b0;
      ca_q <= '0; cd_q <= '0; pidx_q <= '0; pold_q <= '0;
    end else begin
      cv_q   <= conv_we_i && !init_busy_o;
      ca_q   <= conv_addr_i;
      cd_q   <= conv_data_i;
      pr_q   <= conv_we_i && !init_busy_o && cpu_req_i && cpu_we_i
                && addr_region == 2'd0 && addr_idx != conv_addr_i;
      pidx_q <= addr_idx;
      pold_q <= mem_data[addr_idx];
    end
  end

  p_init_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_busy_o && init_start_i |=> init_busy_o);

  p_conv_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cv_q |-> mem_data[ca_q] == cd_q && mem_par[ca_q] == ~^cd_q);

  p_conv_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_q |-> mem_data[pidx_q] == pold_q);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !clr |=> par_err_o);

  p_eidx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !clr |=> $stable(err_idx));

  p_err_from_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> $past(cpu_req_i && !cpu_we_i && addr_region == 2'd0));
endmodule

bind par_result_ram par_result_ram_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_start_i(init_start_i),
  .init_busy_o (init_busy_o),
  .conv_we_i   (conv_we_i),
  .conv_addr_i (conv_addr_i),
  .conv_data_i (conv_data_i),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .addr_region (cpu_addr_i[13:12]),
  .addr_sel    (cpu_addr_i[3:2]),
  .addr_idx    (cpu_addr_i[AW+1:2]),
  .wdata_b0    (cpu_wdata_i[0]),
  .par_err_o   (par_err_o),
  .mem_data    (mem_data),
  .mem_par     (mem_par),
  .err_idx     (err_idx)
);

// File: tb/par_result_ram_bench.sv
module par_result_ram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int AW = 5;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          init_start_i = 1'b0, conv_we_i = 1'b0;
  logic [AW-1:0] conv_addr_i = '0;
  logic [15:0]   conv_data_i = '0;
  logic          cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [13:0]   cpu_addr_i = '0;
  logic [31:0]   cpu_wdata_i = '0;
  logic [31:0]   cpu_rdata_o;
  logic          init_busy_o, par_err_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0]   m_data [DEPTH];
  logic          m_par  [DEPTH];
  logic [3:0]    m_key;
  logic          m_test, m_dw, m_flag;
  logic [AW-1:0] m_eidx;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  par_result_ram #(.DEPTH(DEPTH)) u_par_result_ram (.*);

  function automatic logic oddp(logic [15:0] d);
    return ~^d;
  endfunction

  function automatic logic [13:0] a_mem(int rg, int idx);
    return {2'(rg), 5'b0, 5'(idx), 2'b0};
  endfunction

  function automatic logic [13:0] a_csr(int sel);
    return {2'd2, 8'b0, 2'(sel), 2'b0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model-based cycle: drive at negedge, update model at posedge, check at next negedge
  task automatic step(bit cwe, int caddr, logic [15:0] cdata,
                      bit req, bit we, logic [13:0] addr, logic [31:0] wd,
                      string tag);
    logic [31:0] exp_rd;
    int rg, idx, sel;
    bit fail;
    conv_we_i = cwe; conv_addr_i = AW'(caddr); conv_data_i = cdata;
    cpu_req_i = req; cpu_we_i = we; cpu_addr_i = addr; cpu_wdata_i = wd;
    rg = int'(addr[13:12]); idx = int'(addr[6:2]); sel = int'(addr[3:2]);
    @(posedge clk_i);
    exp_rd = '0;
    fail = 1'b0;
    if (req && !we) begin
      case (rg)
        0: begin
          exp_rd = 32'(m_data[idx]);
          fail = (m_key == 4'hA) && !m_test && ((^m_data[idx]) == m_par[idx]);
        end
        1: exp_rd = m_test ? 32'(m_par[idx]) : 32'h0;
        2: case (sel)
             0: exp_rd = {23'b0, m_test, 4'b0, m_key};
             1: exp_rd = 32'(m_dw);
             2: exp_rd = 32'(m_flag);
             default: exp_rd = 32'(m_eidx);
           endcase
        default: exp_rd = '0;
      endcase
    end
    if (cwe) begin
      m_data[caddr] = cdata; m_par[caddr] = oddp(cdata);
    end else if (req && we) begin
      if (rg == 0 && m_dw) begin
        m_data[idx] = wd[15:0]; m_par[idx] = oddp(wd[15:0]);
      end
      if (rg == 1 && m_test) m_par[idx] = wd[0];
    end
    if (req && we && rg == 2) begin
      if (sel == 0) begin m_key = wd[3:0]; m_test = wd[8]; end
      if (sel == 1) m_dw = wd[0];
    end
    if (req && we && rg == 2 && sel == 2 && wd[0]) m_flag = 1'b0;
    else if (fail && !m_flag) begin m_flag = 1'b1; m_eidx = AW'(idx); end
    @(negedge clk_i);
    if (req && !we) chk({tag, " rdata"}, cpu_rdata_o, exp_rd);
    chk("R9 flag", 32'(par_err_o), 32'(m_flag));
    conv_we_i = 1'b0; cpu_req_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  task automatic wr(logic [13:0] a, logic [31:0] d);
    step(0, 0, 16'h0, 1, 1, a, d, "wr");
  endtask

  task automatic rd(logic [13:0] a, string tag);
    step(0, 0, 16'h0, 1, 0, a, 32'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int busy_cnt;
    void'($urandom(32'd1234));
    m_key = '0; m_test = 0; m_dw = 0; m_flag = 0; m_eidx = '0;
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_par[i] = 1'b1; end
    repeat (3) @(negedge clk_i);
    chk("R13 reset rdata", cpu_rdata_o, 32'h0);
    chk("R13 reset err", 32'(par_err_o), 32'h0);
    chk("R13 reset busy", 32'(init_busy_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: clearing sequence, with a dropped converter write and a second start
    conv_we_i = 1; conv_addr_i = 5'd3; conv_data_i = 16'h5555;
    wr(a_mem(0, 4), 32'h0);
    init_start_i = 1'b1;
    @(negedge clk_i);
    busy_cnt = 0;
    while (init_busy_o && busy_cnt < 100) begin
      init_start_i = (busy_cnt == 5);
      conv_we_i = 1; conv_addr_i = 5'd3; conv_data_i = 16'h5555;
      busy_cnt++;
      @(negedge clk_i);
    end
    init_start_i = 0; conv_we_i = 0;
    chk("R2 busy length", 32'(busy_cnt), 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_par[i] = 1'b1; end
    rd(a_mem(0, 3), "R2 word3 zero");
    rd(a_mem(0, 0), "R2 word0 zero");

    // R1 / R7: parity visible only with test bit
    wr(a_csr(0), 32'h00A);
    rd(a_mem(1, 0), "R7 par hidden");
    wr(a_mem(1, 0), 32'h0);
    wr(a_csr(0), 32'h10A);
    rd(a_mem(1, 0), "R1 zero word parity");
    wr(a_csr(0), 32'h00A);
    rd(a_mem(0, 0), "R7 ignored par write");

    // R4 / R5
    wr(a_mem(0, 5), 32'h1234);
    rd(a_mem(0, 5), "R4 write blocked");
    wr(a_csr(1), 32'h1);
    wr(a_mem(0, 5), 32'hABCD_1234);
    rd(a_mem(0, 5), "R4 write accepted");
    wr(a_csr(0), 32'h10A);
    rd(a_mem(1, 5), "R5 regenerated parity");

    // R8 / R10 / R11: inject faults
    wr(a_mem(1, 5), 32'(~oddp(16'h1234)));
    rd(a_mem(1, 5), "R11 par read no error");
    wr(a_mem(1, 7), 32'h0);
    wr(a_csr(0), 32'h00A);
    rd(a_mem(0, 5), "R8 first fault");
    rd(a_csr(3), "R10 error address");
    rd(a_mem(0, 7), "R8 second fault");
    rd(a_csr(3), "R10 address held");
    wr(a_csr(2), 32'h0);
    rd(a_csr(2), "R9 write zero keeps");
    wr(a_csr(2), 32'h1);
    rd(a_csr(2), "R9 cleared");

    // R6: wrong key disarms
    wr(a_csr(0), 32'h00B);
    rd(a_mem(0, 7), "R6 disarmed read");
    // R3: converter repairs word 7
    step(1, 7, 16'h0F0F, 0, 0, 14'h0, 32'h0, "R3 conv");
    wr(a_csr(0), 32'h00A);
    rd(a_mem(0, 7), "R3 repaired read");

    // R12: same cycle conflicts
    step(1, 9, 16'h1111, 1, 1, a_mem(0, 10), 32'h2222, "R12 conflict");
    rd(a_mem(0, 10), "R12 cpu dropped");
    step(1, 11, 16'h3333, 1, 1, a_mem(0, 11), 32'h4444, "R12 same word");
    rd(a_mem(0, 11), "R12 conv wins");
    rd(14'h3000, "R13 region3");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int r, rg, idx;
      logic [31:0] d;
      bit cwe;
      r = int'($urandom_range(0, 99));
      idx = int'($urandom_range(0, DEPTH - 1));
      d = $urandom();
      cwe = ($urandom_range(0, 3) == 0);
      rg = int'($urandom_range(0, 9));
      if (rg < 4)
        step(cwe, int'($urandom_range(0, DEPTH - 1)), d[31:16], 1, r < 40, a_mem(0, idx), d, "R8 rnd data");
      else if (rg < 7)
        step(cwe, int'($urandom_range(0, DEPTH - 1)), d[31:16], 1, r < 50, a_mem(1, idx), d, "R7 rnd par");
      else if (rg < 9) begin
        case (r % 4)
          0: step(cwe, idx, d[15:0], 1, 1, a_csr(0),
                  {23'b0, d[8], 4'b0, (d[0] ? 4'hA : 4'h5)}, "R6 rnd ctl");
          1: step(cwe, idx, d[15:0], 1, 1, a_csr(1), d, "R4 rnd mode");
          2: step(cwe, idx, d[15:0], 1, r < 60, a_csr(2), d, "R9 rnd stat");
          default: step(cwe, idx, d[15:0], 1, 0, a_csr(3), d, "R10 rnd eadr");
        endcase
      end else
        step(cwe, idx, d[15:0], 0, 0, 14'h0, 32'h0, "R3 rnd conv");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule